// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This unit runs both hardware and software flow control for one UART channel. On the receive side it compares the receive FIFO fill level with two programmable levels: a halt level and a lower resume level. From that comparison it drives an active-low request-to-send line. When software flow control is turned on, it also asks the transmitter to insert an Xoff character when the halt level is reached, and an Xon character when the level falls back to the resume level.

On the transmit side it produces `tx_enable`, which is permission to start a new character. Permission is removed when the synchronised clear-to-send input goes high while CTS gating is on. It is also removed after an Xoff character is received. Permission returns after an Xon character is received, or after any character if the any-character resume mode is on. Received Xon/Xoff characters are marked so that the receive path does not store them.

A transmitter that owns the shift register always finishes the character it has started. `tx_enable` is looked at only before the next start bit. Control-character requests on `ctl_req` are not gated by `tx_enable`.

Top module: `uart_flowctl`

## Requirements
- R1: After a synchronous reset, `rts_n` is 0, `tx_enable` is 1 and `ctl_req` is 0.
- R2: With `cfg_auto_rts`=1, `rts_n` goes to 1 on the clock edge after `rx_level` >= `cfg_halt_lvl`.
- R3: Once high, `rts_n` returns to 0 only on the clock edge after `rx_level` <= `cfg_resume_lvl`. For levels strictly between the two thresholds, `rts_n` keeps its value (hysteresis).
- R4: With `cfg_auto_rts`=0, `rts_n` is 0 whatever the fill level.
- R5: With `cfg_sw_rx_en`=1, the edge that enters the halted state raises `ctl_req` with `ctl_char` = `cfg_xoff_code`. `ctl_req` stays high until the clock edge that samples `ctl_ack`=1, and is low after that edge.
- R6: With `cfg_sw_rx_en`=1, the edge that leaves the halted state raises `ctl_req` with `ctl_char` = `cfg_xon_code`. With `cfg_sw_rx_en`=0, threshold crossings raise no request.
- R7: With `cfg_auto_cts`=1, a level on `cts_n` reaches `tx_enable` after SYNC_STAGES (default 2) clock edges: 1 blocks transmission, 0 allows it. With `cfg_auto_cts`=0, `cts_n` has no effect.
- R8: With `cfg_sw_tx_en`=1, a received character (`rx_char_valid`=1) equal to `cfg_xoff_code` clears `tx_enable` on the next edge. A received `cfg_xon_code` sets it again on the next edge. The Xoff compare takes priority if the two codes are equal.
- R9: With `cfg_any_resume`=1 and the transmitter stopped by Xoff, any received character other than Xoff sets `tx_enable` on the next edge. With `cfg_any_resume`=0, a non-control character leaves it stopped.
- R10: `rx_char_keep` follows `rx_char_valid` in the same cycle, except that it is 0 for a character matching `cfg_xon_code` or `cfg_xoff_code` while `cfg_sw_tx_en`=1.
- R11: Clearing `cfg_sw_tx_en` releases an Xoff stop on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_auto_rts | input | 1 | Drive rts_n from the fill level |
| cfg_auto_cts | input | 1 | Gate transmission with cts_n |
| cfg_sw_rx_en | input | 1 | Request Xoff/Xon on threshold crossings |
| cfg_sw_tx_en | input | 1 | Obey received Xoff/Xon |
| cfg_any_resume | input | 1 | Any received character resumes |
| cfg_halt_lvl | input | 7 | Halt threshold |
| cfg_resume_lvl | input | 7 | Resume threshold (below halt) |
| cfg_xon_code | input | 8 | Xon character code |
| cfg_xoff_code | input | 8 | Xoff character code |
| rx_level | input | 7 | Receive FIFO fill level, 0..64 |
| rx_char_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| ctl_ack | input | 1 | Transmitter has taken the control character |
| rts_n | output | 1 | Request-to-send, active low |
| tx_enable | output | 1 | Permission to start a new character |
| rx_char_keep | output | 1 | Store the received character in the FIFO |
| ctl_req | output | 1 | Control character waiting to be sent |
| ctl_char | output | 8 | Code of the waiting control character |

## Verification
The bench sweeps the fill level up from 0 to 64 and back down for many halt/resume pairs, including halt at 64 and resume at 0 and at halt-1. A design without hysteresis would let `rts_n` fall as soon as the level dropped below halt. An off-by-one compare would move the transitions by one level. The bench checks that exactly one Xoff and one Xon request appear per sweep and that each is held until acknowledged; a design that retriggers on every cycle above the threshold would show requests reappearing after an acknowledge. The CTS latency is probed edge by edge, so both a missing synchroniser and an extra stage are caught. The received-character tests cover Xoff, Xon, ordinary characters with and without any-character resume, and release by disabling the mode; a design that let an ordinary character resume the transmitter when any-character resume is off, or that passed control characters into the FIFO, fails those checks.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic {
        CTL_XON  = 1'b0,
        CTL_XOFF = 1'b1
    } ctl_kind_e;

    typedef struct packed {
        logic      pend;
        ctl_kind_e kind;
    } ctl_slot_t;

    function automatic int lvl_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= 1'b0;
                else     stg[0] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= 1'b0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/fc_rx_throttle.sv
module fc_rx_throttle
    import uart_fc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rts,
    input  logic             sw_rx_en,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    input  logic [7:0]       xon_code,
    input  logic [7:0]       xoff_code,
    input  logic [LVL_W-1:0] level,
    input  logic             ack,
    output logic             rts_n,
    output logic             req,
    output logic [7:0]       req_char
);
    logic      halted, halted_nx;
    ctl_slot_t slot, slot_nx;

    always_comb begin
        halted_nx = halted;
        if (!halted && level >= halt_lvl)     halted_nx = 1'b1;
        else if (halted && level <= resume_lvl) halted_nx = 1'b0;
    end

    always_comb begin
        slot_nx = slot;
        if (ack) slot_nx.pend = 1'b0;
        if (sw_rx_en && (halted_nx != halted)) begin
            slot_nx.pend = 1'b1;
            slot_nx.kind = halted_nx ? CTL_XOFF : CTL_XON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
            slot   <= '{pend: 1'b0, kind: CTL_XON};
        end else begin
            halted <= halted_nx;
            slot   <= slot_nx;
        end
    end

    assign rts_n    = auto_rts & halted;
    assign req      = slot.pend;
    assign req_char = (slot.kind == CTL_XOFF) ? xoff_code : xon_code;

    // R2
    rts_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_rts && resume_lvl < halt_lvl && level >= halt_lvl) |=> (rts_n || !auto_rts));

    // R3
    rts_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (resume_lvl < halt_lvl && level <= resume_lvl) |=> !rts_n);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_tx_en,
    input  logic       any_resume,
    input  logic [7:0] xon_code,
    input  logic [7:0] xoff_code,
    input  logic       char_valid,
    input  logic [7:0] char_in,
    output logic       stopped,
    output logic       keep
);
    logic is_xoff, is_xon;

    assign is_xoff = char_valid && (char_in == xoff_code);
    assign is_xon  = char_valid && (char_in == xon_code);

    always_ff @(posedge clk) begin
        if (rst || !sw_tx_en)                   stopped <= 1'b0;
        else if (is_xoff)                       stopped <= 1'b1;
        else if (is_xon)                        stopped <= 1'b0;
        else if (char_valid && any_resume)      stopped <= 1'b0;
    end

    assign keep = char_valid && !(sw_tx_en && (is_xon || is_xoff));

    // R8
    xoff_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_tx_en && char_valid && char_in == xoff_code) |=> stopped);

    // R11
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_tx_en |=> !stopped);
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = lvl_width(FIFO_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_auto_rts,
    input  logic             cfg_auto_cts,
    input  logic             cfg_sw_rx_en,
    input  logic             cfg_sw_tx_en,
    input  logic             cfg_any_resume,
    input  logic [LVL_W-1:0] cfg_halt_lvl,
    input  logic [LVL_W-1:0] cfg_resume_lvl,
    input  logic [7:0]       cfg_xon_code,
    input  logic [7:0]       cfg_xoff_code,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_char_valid,
    input  logic [7:0]       rx_char,
    input  logic             cts_n,
    input  logic             ctl_ack,
    output logic             rts_n,
    output logic             tx_enable,
    output logic             rx_char_keep,
    output logic             ctl_req,
    output logic [7:0]       ctl_char
);
    logic cts_n_s, sw_stopped;

    fc_cts_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d_in(cts_n), .d_out(cts_n_s)
    );

    fc_rx_throttle #(.LVL_W(LVL_W)) thr_i (
        .clk(clk), .rst(rst),
        .auto_rts(cfg_auto_rts), .sw_rx_en(cfg_sw_rx_en),
        .halt_lvl(cfg_halt_lvl), .resume_lvl(cfg_resume_lvl),
        .xon_code(cfg_xon_code), .xoff_code(cfg_xoff_code),
        .level(rx_level), .ack(ctl_ack),
        .rts_n(rts_n), .req(ctl_req), .req_char(ctl_char)
    );

    fc_tx_gate gate_i (
        .clk(clk), .rst(rst),
        .sw_tx_en(cfg_sw_tx_en), .any_resume(cfg_any_resume),
        .xon_code(cfg_xon_code), .xoff_code(cfg_xoff_code),
        .char_valid(rx_char_valid), .char_in(rx_char),
        .stopped(sw_stopped), .keep(rx_char_keep)
    );

    assign tx_enable = !(cfg_auto_cts && cts_n_s) && !sw_stopped;

    // R7
    cts_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto_cts && cts_n_s) |-> !tx_enable);
endmodule

// File: tb/uart_flowctl_tb_top.sv
module uart_flowctl_tb_top;
    logic clk = 0, rst = 1;
    logic auto_rts = 0, auto_cts = 0, sw_rx = 0, sw_tx = 0, any_res = 0;
    logic [6:0] halt = 7'd32, resume = 7'd16, level = 0;
    logic [7:0] xon = 8'h11, xoff = 8'h13, ch = 0;
    logic cv = 0, cts_n = 0, ack = 0;
    logic rts_n, tx_en, keep, req;
    logic [7:0] cchar;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    uart_flowctl dut_i (
        .clk(clk), .rst(rst), .cfg_auto_rts(auto_rts), .cfg_auto_cts(auto_cts),
        .cfg_sw_rx_en(sw_rx), .cfg_sw_tx_en(sw_tx), .cfg_any_resume(any_res),
        .cfg_halt_lvl(halt), .cfg_resume_lvl(resume), .cfg_xon_code(xon),
        .cfg_xoff_code(xoff), .rx_level(level), .rx_char_valid(cv), .rx_char(ch),
        .cts_n(cts_n), .ctl_ack(ack), .rts_n(rts_n), .tx_enable(tx_en),
        .rx_char_keep(keep), .ctl_req(req), .ctl_char(cchar)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    bit   m_halt, m_pend, m_kind;

    task automatic lvl_step(input int v);
        level = 7'(v);
        tick();
        if (!m_halt && v >= halt) begin
            m_halt = 1; if (sw_rx) begin m_pend = 1; m_kind = 1; end
        end else if (m_halt && v <= resume) begin
            m_halt = 0; if (sw_rx) begin m_pend = 1; m_kind = 0; end
        end
        chk("R2/R3/R4 rts_n", {7'd0, rts_n}, {7'd0, m_halt & auto_rts});
        chk("R5/R6 ctl_req", {7'd0, req}, {7'd0, m_pend});
        if (m_pend) begin
            chk("R5/R6 ctl_char", cchar, m_kind ? xoff : xon);
            ack = 1; tick(); ack = 0; m_pend = 0;
            chk("R5 ack clears", {7'd0, req}, 8'd0);
        end
    endtask

    task automatic sweep(input int h, input int r, input bit ar, input bit sr);
        halt = 7'(h); resume = 7'(r); auto_rts = ar; sw_rx = sr;
        for (int v = 0; v <= 64; v++) lvl_step(v);
        for (int v = 64; v >= 0; v--) lvl_step(v);
    endtask

    task automatic rx_send(input logic [7:0] c, input bit exp_keep, input bit exp_en, input string tag);
        ch = c; cv = 1; #1;
        chk({tag, " keep"}, {7'd0, keep}, {7'd0, exp_keep});
        tick(); cv = 0;
        chk({tag, " tx_enable"}, {7'd0, tx_en}, {7'd0, exp_en});
    endtask

    initial begin
        #200000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(); tick(); rst = 0;
        // R1
        chk("R1 rts_n", {7'd0, rts_n}, 8'd0);
        chk("R1 tx_enable", {7'd0, tx_en}, 8'd1);
        chk("R1 ctl_req", {7'd0, req}, 8'd0);

        // R2 R3 R5 R6: sweeps
        m_halt = 0; m_pend = 0; m_kind = 0;
        for (int h = 8; h <= 64; h += 8) begin
            sweep(h, 0, 1, 1);
            sweep(h, h / 2, 1, 1);
            sweep(h, h - 1, 1, 0);
        end
        // R4: auto rts off, R6: no requests when sw_rx off
        sweep(20, 10, 0, 0);
        sweep(64, 0, 0, 1);
        level = 0; tick();

        // R7: CTS latency
        auto_cts = 1; cts_n = 1; tick();
        chk("R7 one edge no effect", {7'd0, tx_en}, 8'd1);
        tick();
        chk("R7 blocked after two", {7'd0, tx_en}, 8'd0);
        cts_n = 0; tick();
        chk("R7 still blocked", {7'd0, tx_en}, 8'd0);
        tick();
        chk("R7 released", {7'd0, tx_en}, 8'd1);
        auto_cts = 0; cts_n = 1; tick(); tick(); tick();
        chk("R7 cts ignored when off", {7'd0, tx_en}, 8'd1);
        cts_n = 0; tick(); tick();

        // R10: control chars kept when software mode off
        sw_tx = 0;
        rx_send(xoff, 1, 1, "R10 xoff passes when off");
        sw_tx = 1; any_res = 0;
        // R8
        rx_send(xoff, 0, 0, "R8 xoff stops");
        // R9 with any_resume off
        rx_send(8'h41, 1, 0, "R9 plain char no resume");
        rx_send(xon, 0, 1, "R8 xon resumes");
        // R9 any resume
        any_res = 1;
        rx_send(xoff, 0, 0, "R8 xoff again");
        rx_send(8'h42, 1, 1, "R9 any char resumes");
        // R11
        rx_send(xoff, 0, 0, "R11 stop");
        sw_tx = 0; tick();
        chk("R11 released by disable", {7'd0, tx_en}, 8'd1);
        // R10 sweep over all codes
        sw_tx = 1; any_res = 0;
        for (int c = 0; c < 256; c++) begin
            if (c == 8'h13) continue;
            ch = 8'(c); cv = 1; #1;
            chk("R10 keep", {7'd0, keep}, {7'd0, (c != xon)});
            tick(); cv = 0;
        end
        cv = 0; #1;
        chk("R10 no strobe", {7'd0, keep}, 8'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule